// File: doc/BRIEF.md
# Triple-DES CBC Block Engine

This block encrypts or decrypts 64-bit blocks with three-key Triple DES, chained in Cipher Block Chaining mode. One round-serial DES datapath is shared by all three passes of a block. It runs one Feistel round per clock, so a block occupies the engine for 48 cycles. The engine applies the chaining XOR itself and keeps the chaining value in an internal register. A caller loads an initialization vector, holds the three keys steady, and presents blocks one at a time. Each result comes back with a one-cycle valid pulse.

Encryption runs encrypt with the first key, then decrypt with the second key, then encrypt with the third key. Decryption runs the mirror image: decrypt with the third key, encrypt with the second key, decrypt with the first key. The keys are read directly from the ports throughout a block, so they must not change while the engine is busy.

Top module: `tdes_cbc_core`

## Requirements
- R1: While reset is asserted and right after it is released, `busy` and `out_valid` are 0 and `out_data` is all zeros.
- R2: A block is accepted only when `busy` is 0. A `blk_valid` pulse that arrives while busy starts no new block and produces no extra output pulse.
- R3: `busy` rises on the clock edge that accepts a block and stays high for exactly 48 cycles. `out_valid` is a single-cycle pulse that rises on the same edge where `busy` falls, 48 edges after the accepting edge.
- R4: With `decrypt` = 0, the three passes are encrypt(key1), decrypt(key2), encrypt(key3). When key1 = key2, the result is single DES encryption under key3.
- R5: With `decrypt` = 1, the three passes are decrypt(key3), encrypt(key2), decrypt(key1). When key2 = key3, the result is single DES decryption under key1.
- R6: When all three keys are equal, the engine gives the same result as single DES in both directions.
- R7: On encryption, the block is XORed with the chaining value before the cipher runs, and the ciphertext becomes the new chaining value.
- R8: On decryption, the cipher output is XORed with the chaining value, and the received ciphertext block becomes the new chaining value.
- R9: `iv_load` while idle copies `iv` into the chaining register. If `blk_valid` arrives in the same cycle, that block is chained with the new `iv`. `iv_load` while busy is ignored.
- R10: Under chaining, two equal plaintext blocks encrypted one after the other give different ciphertexts.
- R11: With three distinct keys, decrypting a ciphertext chain from the same IV returns the original plaintext blocks.
- R12: `out_data` keeps its value between output pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| key1 | input | 64 | First key (parity bits unused) |
| key2 | input | 64 | Second key |
| key3 | input | 64 | Third key |
| iv | input | 64 | Initialization vector |
| iv_load | input | 1 | Load `iv` into the chaining register when idle |
| blk_valid | input | 1 | Start a block when idle |
| blk_data | input | 64 | Plaintext or ciphertext block |
| decrypt | input | 1 | 0 encrypts, 1 decrypts; sampled with `blk_valid` |
| busy | output | 1 | High while a block is in progress |
| out_valid | output | 1 | One-cycle pulse when `out_data` is new |
| out_data | output | 64 | Result block |

## Verification
The equal-key cases are compared against well-known single-DES answers. These tell a correct cipher core apart from a wrong table, bit order or round-key order. Pairs of equal keys (key1 = key2 on encryption, key2 = key3 on decryption) are used to isolate which key drives the outer pass. A swapped pass order fails those answers. Two-block chains fed with a crafted IV and a crafted second block show whether the chaining register takes the ciphertext on encryption and the input block on decryption. Repeated plaintexts under three distinct keys, decrypted back, confirm chaining and round-trip integrity. A block and an IV presented while busy must leave both the output and the next chained result untouched.

// File: rtl/tdes_pkg.sv
package tdes_pkg;

    localparam int BLK_W  = 64;
    localparam int HALF_W = BLK_W / 2;
    localparam int KEY_W  = 64;
    localparam int CD_W   = 56;
    localparam int HCD_W  = CD_W / 2;
    localparam int SUB_W  = 48;
    localparam int ROUNDS = 16;
    localparam int PASSES = 3;
    localparam int NSBOX  = 8;
    localparam int RND_W  = $clog2(ROUNDS);
    localparam int PASS_W = $clog2(PASSES + 1);

    // Bit positions count from 1 at the most significant end.
    localparam int IPT [64] = '{
        58, 50, 42, 34, 26, 18, 10, 2, 60, 52, 44, 36, 28, 20, 12, 4,
        62, 54, 46, 38, 30, 22, 14, 6, 64, 56, 48, 40, 32, 24, 16, 8,
        57, 49, 41, 33, 25, 17, 9, 1, 59, 51, 43, 35, 27, 19, 11, 3,
        61, 53, 45, 37, 29, 21, 13, 5, 63, 55, 47, 39, 31, 23, 15, 7};

    localparam int PT [32] = '{
        16, 7, 20, 21, 29, 12, 28, 17, 1, 15, 23, 26, 5, 18, 31, 10,
        2, 8, 24, 14, 32, 27, 3, 9, 19, 13, 30, 6, 22, 11, 4, 25};

    localparam int PC1T [56] = '{
        57, 49, 41, 33, 25, 17, 9, 1, 58, 50, 42, 34, 26, 18,
        10, 2, 59, 51, 43, 35, 27, 19, 11, 3, 60, 52, 44, 36,
        63, 55, 47, 39, 31, 23, 15, 7, 62, 54, 46, 38, 30, 22,
        14, 6, 61, 53, 45, 37, 29, 21, 13, 5, 28, 20, 12, 4};

    localparam int PC2T [48] = '{
        14, 17, 11, 24, 1, 5, 3, 28, 15, 6, 21, 10,
        23, 19, 12, 4, 26, 8, 16, 7, 27, 20, 13, 2,
        41, 52, 31, 37, 47, 55, 30, 40, 51, 45, 33, 48,
        44, 49, 39, 56, 34, 53, 46, 42, 50, 36, 29, 32};

    // Total left rotation of each key half before the given round.
    localparam int ROTT [16] = '{1, 2, 4, 6, 8, 10, 12, 14, 15, 17, 19, 21, 23, 25, 27, 28};

    localparam int SB0 [64] = '{
        14, 4, 13, 1, 2, 15, 11, 8, 3, 10, 6, 12, 5, 9, 0, 7,
        0, 15, 7, 4, 14, 2, 13, 1, 10, 6, 12, 11, 9, 5, 3, 8,
        4, 1, 14, 8, 13, 6, 2, 11, 15, 12, 9, 7, 3, 10, 5, 0,
        15, 12, 8, 2, 4, 9, 1, 7, 5, 11, 3, 14, 10, 0, 6, 13};
    localparam int SB1 [64] = '{
        15, 1, 8, 14, 6, 11, 3, 4, 9, 7, 2, 13, 12, 0, 5, 10,
        3, 13, 4, 7, 15, 2, 8, 14, 12, 0, 1, 10, 6, 9, 11, 5,
        0, 14, 7, 11, 10, 4, 13, 1, 5, 8, 12, 6, 9, 3, 2, 15,
        13, 8, 10, 1, 3, 15, 4, 2, 11, 6, 7, 12, 0, 5, 14, 9};
    localparam int SB2 [64] = '{
        10, 0, 9, 14, 6, 3, 15, 5, 1, 13, 12, 7, 11, 4, 2, 8,
        13, 7, 0, 9, 3, 4, 6, 10, 2, 8, 5, 14, 12, 11, 15, 1,
        13, 6, 4, 9, 8, 15, 3, 0, 11, 1, 2, 12, 5, 10, 14, 7,
        1, 10, 13, 0, 6, 9, 8, 7, 4, 15, 14, 3, 11, 5, 2, 12};
    localparam int SB3 [64] = '{
        7, 13, 14, 3, 0, 6, 9, 10, 1, 2, 8, 5, 11, 12, 4, 15,
        13, 8, 11, 5, 6, 15, 0, 3, 4, 7, 2, 12, 1, 10, 14, 9,
        10, 6, 9, 0, 12, 11, 7, 13, 15, 1, 3, 14, 5, 2, 8, 4,
        3, 15, 0, 6, 10, 1, 13, 8, 9, 4, 5, 11, 12, 7, 2, 14};
    localparam int SB4 [64] = '{
        2, 12, 4, 1, 7, 10, 11, 6, 8, 5, 3, 15, 13, 0, 14, 9,
        14, 11, 2, 12, 4, 7, 13, 1, 5, 0, 15, 10, 3, 9, 8, 6,
        4, 2, 1, 11, 10, 13, 7, 8, 15, 9, 12, 5, 6, 3, 0, 14,
        11, 8, 12, 7, 1, 14, 2, 13, 6, 15, 0, 9, 10, 4, 5, 3};
    localparam int SB5 [64] = '{
        12, 1, 10, 15, 9, 2, 6, 8, 0, 13, 3, 4, 14, 7, 5, 11,
        10, 15, 4, 2, 7, 12, 9, 5, 6, 1, 13, 14, 0, 11, 3, 8,
        9, 14, 15, 5, 2, 8, 12, 3, 7, 0, 4, 10, 1, 13, 11, 6,
        4, 3, 2, 12, 9, 5, 15, 10, 11, 14, 1, 7, 6, 0, 8, 13};
    localparam int SB6 [64] = '{
        4, 11, 2, 14, 15, 0, 8, 13, 3, 12, 9, 7, 5, 10, 6, 1,
        13, 0, 11, 7, 4, 9, 1, 10, 14, 3, 5, 12, 2, 15, 8, 6,
        1, 4, 11, 13, 12, 3, 7, 14, 10, 15, 6, 8, 0, 5, 9, 2,
        6, 11, 13, 8, 1, 4, 10, 7, 9, 5, 0, 15, 14, 2, 3, 12};
    localparam int SB7 [64] = '{
        13, 2, 8, 4, 6, 15, 11, 1, 10, 9, 3, 14, 5, 0, 12, 7,
        1, 15, 13, 8, 10, 3, 7, 4, 12, 5, 6, 11, 0, 14, 9, 2,
        7, 11, 4, 1, 9, 12, 14, 2, 0, 6, 10, 13, 15, 3, 5, 8,
        2, 1, 14, 7, 4, 10, 8, 13, 15, 12, 9, 0, 3, 5, 6, 11};

    function automatic logic [BLK_W-1:0] perm_in(input logic [BLK_W-1:0] x);
        logic [BLK_W-1:0] y;
        y = '0;
        for (int i = 0; i < BLK_W; i++) y[BLK_W-1-i] = x[BLK_W-IPT[i]];
        return y;
    endfunction

    // Inverse of perm_in, derived from the same table.
    function automatic logic [BLK_W-1:0] perm_out(input logic [BLK_W-1:0] x);
        logic [BLK_W-1:0] y;
        y = '0;
        for (int i = 0; i < BLK_W; i++) y[BLK_W-IPT[i]] = x[BLK_W-1-i];
        return y;
    endfunction

    // Each 6-bit group takes 4 source bits plus one neighbour on each side.
    function automatic logic [SUB_W-1:0] expand(input logic [HALF_W-1:0] r);
        logic [SUB_W-1:0] y;
        int src;
        y = '0;
        for (int i = 0; i < SUB_W; i++) begin
            src = ((4 * (i / 6) + (i % 6) + HALF_W - 1) % HALF_W) + 1;
            y[SUB_W-1-i] = r[HALF_W-src];
        end
        return y;
    endfunction

    function automatic logic [HALF_W-1:0] pbox(input logic [HALF_W-1:0] x);
        logic [HALF_W-1:0] y;
        y = '0;
        for (int i = 0; i < HALF_W; i++) y[HALF_W-1-i] = x[HALF_W-PT[i]];
        return y;
    endfunction

    function automatic logic [CD_W-1:0] key_pc1(input logic [KEY_W-1:0] k);
        logic [CD_W-1:0] y;
        y = '0;
        for (int i = 0; i < CD_W; i++) y[CD_W-1-i] = k[KEY_W-PC1T[i]];
        return y;
    endfunction

    function automatic logic [SUB_W-1:0] key_pc2(input logic [CD_W-1:0] cd);
        logic [SUB_W-1:0] y;
        y = '0;
        for (int i = 0; i < SUB_W; i++) y[SUB_W-1-i] = cd[CD_W-PC2T[i]];
        return y;
    endfunction

    // Row comes from the outer bits, column from the inner four.
    function automatic logic [3:0] sbox(input int n, input logic [5:0] x);
        logic [5:0] idx;
        int v;
        idx = {x[5], x[0], x[4:1]};
        case (n)
            0:       v = SB0[idx];
            1:       v = SB1[idx];
            2:       v = SB2[idx];
            3:       v = SB3[idx];
            4:       v = SB4[idx];
            5:       v = SB5[idx];
            6:       v = SB6[idx];
            default: v = SB7[idx];
        endcase
        return 4'(v);
    endfunction

    typedef struct packed {
        logic                  running;
        logic [PASS_W-1:0]     pass;
        logic [RND_W-1:0]      rnd;
        logic [HALF_W-1:0]     l;
        logic [HALF_W-1:0]     r;
        logic                  dec;
        logic [BLK_W-1:0]      chain;
        logic [BLK_W-1:0]      held;
        logic                  ovld;
        logic [BLK_W-1:0]      odata;
    } eng_state_t;

endpackage

// File: rtl/tdes_subkey.sv
module tdes_subkey
    import tdes_pkg::*;
(
    input  logic [KEY_W-1:0] key,
    input  logic [RND_W-1:0] rnd,
    input  logic             inv,
    output logic [SUB_W-1:0] subkey
);
    logic [CD_W-1:0]    cd;
    logic [RND_W-1:0]   eff;
    logic [HCD_W-1:0]   c_rot, d_rot;
    logic [2*HCD_W-1:0] c_dbl, d_dbl;
    int                 sh;

    always_comb begin
        cd     = key_pc1(key);
        // Decryption walks the round keys from last to first.
        eff    = inv ? (RND_W'(ROUNDS - 1) - rnd) : rnd;
        sh     = ROTT[eff];
        c_dbl  = {cd[CD_W-1:HCD_W], cd[CD_W-1:HCD_W]};
        d_dbl  = {cd[HCD_W-1:0], cd[HCD_W-1:0]};
        c_rot  = c_dbl[(2*HCD_W-1-sh) -: HCD_W];
        d_rot  = d_dbl[(2*HCD_W-1-sh) -: HCD_W];
        subkey = key_pc2({c_rot, d_rot});
    end
endmodule

// File: rtl/tdes_round.sv
module tdes_round
    import tdes_pkg::*;
(
    input  logic [HALF_W-1:0] l_in,
    input  logic [HALF_W-1:0] r_in,
    input  logic [SUB_W-1:0]  subkey,
    output logic [HALF_W-1:0] r_out
);
    logic [SUB_W-1:0]  mixed;
    logic [HALF_W-1:0] sub_out;

    assign mixed = expand(r_in) ^ subkey;

    for (genvar g = 0; g < NSBOX; g++) begin : g_sbox
        assign sub_out[HALF_W-1-4*g -: 4] = sbox(g, mixed[SUB_W-1-6*g -: 6]);
    end

    assign r_out = l_in ^ pbox(sub_out);
endmodule

// File: rtl/tdes_pass_sel.sv
module tdes_pass_sel
    import tdes_pkg::*;
(
    input  logic [PASS_W-1:0] pass,
    input  logic              dec,
    input  logic [KEY_W-1:0]  key1,
    input  logic [KEY_W-1:0]  key2,
    input  logic [KEY_W-1:0]  key3,
    output logic [KEY_W-1:0]  key_cur,
    output logic              inv
);
    always_comb begin
        // The middle pass runs opposite to the outer ones.
        inv = dec ^ (pass == PASS_W'(1));
        if (pass == PASS_W'(0))      key_cur = dec ? key3 : key1;
        else if (pass == PASS_W'(1)) key_cur = key2;
        else                         key_cur = dec ? key1 : key3;
    end
endmodule

// File: rtl/tdes_cbc_core.sv
module tdes_cbc_core
    import tdes_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [KEY_W-1:0] key1,
    input  logic [KEY_W-1:0] key2,
    input  logic [KEY_W-1:0] key3,
    input  logic [BLK_W-1:0] iv,
    input  logic             iv_load,
    input  logic             blk_valid,
    input  logic [BLK_W-1:0] blk_data,
    input  logic             decrypt,
    output logic             busy,
    output logic             out_valid,
    output logic [BLK_W-1:0] out_data
);
    localparam logic [RND_W-1:0]  LAST_RND  = RND_W'(ROUNDS - 1);
    localparam logic [PASS_W-1:0] LAST_PASS = PASS_W'(PASSES - 1);

    eng_state_t st_q, st_d;

    logic [KEY_W-1:0]  key_cur;
    logic              inv;
    logic [SUB_W-1:0]  subkey;
    logic [HALF_W-1:0] new_r;
    logic [BLK_W-1:0]  chain_use, din, lr, res;

    tdes_pass_sel u_sel (
        .pass    (st_q.pass),
        .dec     (st_q.dec),
        .key1    (key1),
        .key2    (key2),
        .key3    (key3),
        .key_cur (key_cur),
        .inv     (inv)
    );

    tdes_subkey u_key (
        .key    (key_cur),
        .rnd    (st_q.rnd),
        .inv    (inv),
        .subkey (subkey)
    );

    tdes_round u_round (
        .l_in   (st_q.l),
        .r_in   (st_q.r),
        .subkey (subkey),
        .r_out  (new_r)
    );

    always_comb begin
        st_d      = st_q;
        st_d.ovld = 1'b0;
        chain_use = iv_load ? iv : st_q.chain;
        din       = decrypt ? blk_data : (blk_data ^ chain_use);
        lr        = perm_in(din);
        res       = perm_out({new_r, st_q.r});

        if (!st_q.running) begin
            if (iv_load) st_d.chain = iv;
            if (blk_valid) begin
                st_d.running = 1'b1;
                st_d.pass    = '0;
                st_d.rnd     = '0;
                st_d.l       = lr[BLK_W-1:HALF_W];
                st_d.r       = lr[HALF_W-1:0];
                st_d.dec     = decrypt;
                st_d.held    = blk_data;
            end
        end else if (st_q.rnd != LAST_RND) begin
            st_d.l   = st_q.r;
            st_d.r   = new_r;
            st_d.rnd = st_q.rnd + RND_W'(1);
        end else if (st_q.pass != LAST_PASS) begin
            // Final and initial permutations cancel between passes: swap only.
            st_d.l    = new_r;
            st_d.r    = st_q.r;
            st_d.rnd  = '0;
            st_d.pass = st_q.pass + PASS_W'(1);
        end else begin
            st_d.running = 1'b0;
            st_d.ovld    = 1'b1;
            if (st_q.dec) begin
                st_d.odata = res ^ st_q.chain;
                st_d.chain = st_q.held;
            end else begin
                st_d.odata = res;
                st_d.chain = res;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy      = st_q.running;
    assign out_valid = st_q.ovld;
    assign out_data  = st_q.odata;
endmodule

// File: rtl/tdes_cbc_chk.sv
module tdes_cbc_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        blk_valid,
    input logic        busy,
    input logic        out_valid,
    input logic [63:0] out_data
);
    logic [6:0] busy_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    busy_cnt <= '0;
        else if (busy) busy_cnt <= busy_cnt + 7'd1;
        else           busy_cnt <= '0;
    end

    AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (busy_cnt == 7'd48)); // R3

    AST_PULSE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $fell(busy)); // R3

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid); // R3

    AST_START_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(blk_valid)); // R2

    AST_IDLE_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && blk_valid) |=> busy); // R2

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_data)); // R12
endmodule

bind tdes_cbc_core tdes_cbc_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .blk_valid (blk_valid),
    .busy      (busy),
    .out_valid (out_valid),
    .out_data  (out_data)
);

// File: tb/sim_tdes_cbc_core.sv
module sim_tdes_cbc_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] key1 = '0, key2 = '0, key3 = '0, iv = '0, blk_data = '0;
    logic        iv_load = 1'b0, blk_valid = 1'b0, decrypt = 1'b0;
    logic        busy, out_valid;
    logic [63:0] out_data;

    int errs = 0;
    int checks = 0;
    int cyc = 0;

    localparam logic [63:0] KA = 64'h133457799BBCDFF1;
    localparam logic [63:0] PA = 64'h0123456789ABCDEF;
    localparam logic [63:0] CA = 64'h85E813540F0AB405;
    localparam logic [63:0] KB = 64'h0123456789ABCDEF;
    localparam logic [63:0] PB = 64'h4E6F772069732074;
    localparam logic [63:0] CB = 64'h3FA40E8A984D4815;
    localparam logic [63:0] KC = 64'h0E329232EA6D0D73;

    always #10 clk = ~clk;

    tdes_cbc_core u0 (
        .clk(clk), .rst_n(rst_n), .key1(key1), .key2(key2), .key3(key3),
        .iv(iv), .iv_load(iv_load), .blk_valid(blk_valid), .blk_data(blk_data),
        .decrypt(decrypt), .busy(busy), .out_valid(out_valid), .out_data(out_data)
    );

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errs, checks);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errs++;
            $display("FAIL watchdog: actual %0d cycles expected fewer than 150000", cyc);
            summary();
            $finish;
        end
    end

    task automatic chk64(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic chki(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic set_keys(input logic [63:0] a, input logic [63:0] b, input logic [63:0] c);
        key1 = a; key2 = b; key3 = c;
    endtask

    task automatic load_iv(input logic [63:0] v);
        iv = v; iv_load = 1'b1;
        @(negedge clk);
        iv_load = 1'b0;
    endtask

    // Runs one block from a negedge and checks its timing (R3); poke adds
    // a block and an IV load while busy (R2, R9).
    task automatic run_block(input logic dec, input logic [63:0] data, input logic ld,
                             input logic [63:0] ivv, input logic poke, output logic [63:0] res);
        int n;
        int busy_n;
        int extra;
        bit done;
        blk_valid = 1'b1; blk_data = data; decrypt = dec;
        iv_load = ld; iv = ivv;
        @(negedge clk);
        blk_valid = 1'b0; iv_load = 1'b0; blk_data = '0;
        n = 1; busy_n = 0; done = 0;
        while (!done && n < 200) begin
            if (busy) busy_n++;
            if (poke && n == 10) begin
                blk_valid = 1'b1; blk_data = ~data; decrypt = ~dec;
                iv_load = 1'b1; iv = 64'hDEADBEEFCAFEF00D;
            end else begin
                blk_valid = 1'b0; iv_load = 1'b0; decrypt = dec;
            end
            if (out_valid) done = 1;
            else begin
                @(negedge clk);
                n++;
            end
        end
        blk_valid = 1'b0; iv_load = 1'b0;
        chki("R3", "edges from accept to output", n - 1, 48);
        chki("R3", "busy cycles", busy_n, 48);
        chki("R3", "busy low with output", int'(busy), 0);
        res = out_data;
        @(negedge clk);
        chki("R3", "pulse width", int'(out_valid), 0);
        if (poke) begin
            extra = 0;
            for (int i = 0; i < 60; i++) begin
                if (out_valid || busy) extra++;
                @(negedge clk);
            end
            chki("R2", "activity after block offered while busy", extra, 0);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chki("R1", "busy in reset", int'(busy), 0);
        chki("R1", "out_valid in reset", int'(out_valid), 0);
        chk64("R1", "out_data in reset", out_data, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chki("R1", "busy after reset", int'(busy), 0);
        chk64("R1", "out_data after reset", out_data, 64'h0);
    endtask

    task automatic t_equal_keys();
        logic [63:0] r;
        set_keys(KA, KA, KA);
        run_block(1'b0, PA, 1'b1, 64'h0, 1'b0, r);
        chk64("R6", "equal keys encrypt (R9 same-cycle IV)", r, CA);
        run_block(1'b1, CA, 1'b1, 64'h0, 1'b0, r);
        chk64("R6", "equal keys decrypt", r, PA);
    endtask

    task automatic t_enc_order();
        logic [63:0] r;
        set_keys(KC, KC, KB);
        run_block(1'b0, PB, 1'b1, 64'h0, 1'b0, r);
        chk64("R4", "key1=key2 gives single encrypt under key3", r, CB);
    endtask

    task automatic t_dec_order();
        logic [63:0] r;
        set_keys(KB, KC, KC);
        run_block(1'b1, CB, 1'b1, 64'h0, 1'b0, r);
        chk64("R5", "key2=key3 gives single decrypt under key1", r, PB);
    endtask

    task automatic t_cbc();
        logic [63:0] c1, c2, p1, p2, r;
        set_keys(KB, KB, KB);
        p1 = PB ^ 64'hA5A5A5A5A5A5A5A5;
        load_iv(64'hA5A5A5A5A5A5A5A5);
        run_block(1'b0, p1, 1'b0, 64'h0, 1'b0, c1);
        chk64("R7", "first block chained with IV", c1, CB);
        p2 = PB ^ CB;
        run_block(1'b0, p2, 1'b0, 64'h0, 1'b0, c2);
        chk64("R7", "second block chained with ciphertext", c2, CB);
        load_iv(64'hA5A5A5A5A5A5A5A5);
        run_block(1'b1, CB, 1'b0, 64'h0, 1'b0, r);
        chk64("R8", "decrypt first block", r, p1);
        run_block(1'b1, CB, 1'b0, 64'h0, 1'b0, r);
        chk64("R8", "decrypt second block chains input", r, p2);
    endtask

    task automatic t_distinct();
        logic [63:0] c1, c2, r;
        set_keys(64'h0123456789ABCDEF, 64'h23456789ABCDEF01, 64'h456789ABCDEF0123);
        load_iv(64'h0F1E2D3C4B5A6978);
        run_block(1'b0, 64'h5468652071756663, 1'b0, 64'h0, 1'b0, c1);
        run_block(1'b0, 64'h5468652071756663, 1'b0, 64'h0, 1'b0, c2);
        chki("R10", "repeated plaintext differs", int'(c1 != c2), 1);
        load_iv(64'h0F1E2D3C4B5A6978);
        run_block(1'b1, c1, 1'b0, 64'h0, 1'b0, r);
        chk64("R11", "round trip block 1", r, 64'h5468652071756663);
        run_block(1'b1, c2, 1'b0, 64'h0, 1'b0, r);
        chk64("R11", "round trip block 2", r, 64'h5468652071756663);
    endtask

    task automatic t_busy_ignore();
        logic [63:0] r;
        set_keys(KA, KA, KA);
        load_iv(64'h0);
        run_block(1'b0, PA, 1'b0, 64'h0, 1'b1, r);
        chk64("R2", "result unaffected by block offered while busy", r, CA);
        repeat (5) @(negedge clk);
        chk64("R12", "out_data held", out_data, CA);
        run_block(1'b0, PA ^ CA, 1'b0, 64'h0, 1'b0, r);
        chk64("R9", "IV load while busy ignored", r, CA);
    endtask

    initial begin
        t_reset();
        t_equal_keys();
        t_enc_order();
        t_dec_order();
        t_cbc();
        t_distinct();
        t_busy_ignore();
        summary();
        $finish;
    end
endmodule